// File: doc/BRIEF.md
# Microcoded Single-Bus Control Sequencer

This block is a control unit whose behaviour lives in a small control store rather than in decode gates. A micro-program counter steps through microinstructions. Each word gates one register transfer over a single shared 32-bit operand bus. The same block holds a minimal datapath: 32 general registers, a program counter, an instruction register, address and data latches, an ALU input latch and an ALU result latch.

Each word's register enable uses vertical encoding: a register number, a choice of where that number comes from (a literal or one of the instruction's register fields) and one in/out bit. There are no individual enable lines. An address generator chooses the next micro-address. It can step forward, wait for memory, dispatch on the opcode, return to the fetch routine, or stay halted.

The block talks to the outside world through two streams. The first is an instruction-read channel: a request with an address, and a response with data. The second is an outgoing register write-back stream that reports every general-register update. A user connects a memory that answers reads and, if wanted, an observer of the write-back stream.

Top module: `useq_core`

## Requirements
- R1: While `rst` is high, `pc_o` equals `PC_RESET` (default 0), `err_o` is low and `wb_valid_o` is low. The first read request after reset carries address `PC_RESET`.
- R2: Each instruction starts with one read request whose address equals the program counter. The program counter then advances by exactly 4 once per instruction and changes in no other way.
- R3: Once `mem_rd_o` rises, it stays high and `mem_addr_o` stays stable until a cycle in which `mem_rvalid_i` is high while the sequencer waits to load the instruction register. The sequencer waits any number of cycles for that response.
- R4: An instruction word carries the opcode in bits 31:24, the destination register in 20:16, source 1 in 15:11 and source 2 in 10:6. Opcode 0x01 writes destination = source 1 + source 2, modulo 2^32.
- R5: After reset, general register k holds k × `REG_SEED` modulo 2^32 (default seed 0x10010203).
- R6: Every general-register write appears on the write-back stream as register number and value. The write takes effect only in a cycle with `wb_valid_o` and `wb_ready_i` both high. While `wb_ready_i` is low, the sequencer holds, and `wb_reg_o` and `wb_data_o` do not change.
- R7: Opcode 0x00 returns control to the fetch routine without any register write.
- R8: Any opcode other than 0x00 and 0x01 raises `err_o` and keeps it high until reset. After that, no further read request or write-back occurs and `pc_o` stays frozen.
- R9: A register may be named as both sources, and the destination may equal a source. The result is computed from the values held before the instruction.
- R10: With immediate memory responses and `wb_ready_i` high, one register add takes 7 cycles from the start of its read request to the start of the next, and opcode 0x00 takes 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_rd_o | output | 1 | Instruction read request (valid) |
| mem_addr_o | output | 32 | Byte address of the read |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 32 | Read response data |
| wb_valid_o | output | 1 | Register write-back valid |
| wb_ready_i | input | 1 | Register write-back ready |
| wb_reg_o | output | 5 | Register being written |
| wb_data_o | output | 32 | Value being written |
| pc_o | output | 32 | Current program counter |
| err_o | output | 1 | Illegal opcode seen; sequencing halted |

## Verification
The assertions rely on the memory following two rules. It may raise `mem_rvalid_i` only while `mem_rd_o` is high. Once raised, it must keep it high with matching data until the request drops. The bench memory obeys these rules: its response is a function of the held address and a per-request wait count, and it clears the valid bit whenever no request is present.

The assertions place no constraint on `wb_ready_i`. The stimulus first runs with immediate responses and ready held high, so the cycle counts of R10 can be checked. After that it adds memory waits of one to three cycles and holds ready low for two cycles out of every three.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int XLEN      = 32;
  localparam int GPR_COUNT = 32;
  localparam int GPR_IDX_W = $clog2(GPR_COUNT);
  localparam int UADDR_W   = 6;
  localparam int UDEPTH    = 1 << UADDR_W;

  // instruction word field positions
  localparam int OPC_LSB = 24;
  localparam int DST_LSB = 16;
  localparam int S1_LSB  = 11;
  localparam int S2_LSB  = 6;

  localparam logic [7:0] OP_NOP = 8'h00;
  localparam logic [7:0] OP_ADD = 8'h01;

  // microroutine entry points
  localparam logic [UADDR_W-1:0] UA_FETCH = 6'd0;
  localparam logic [UADDR_W-1:0] UA_FET2  = 6'd1;
  localparam logic [UADDR_W-1:0] UA_FET3  = 6'd2;
  localparam logic [UADDR_W-1:0] UA_FET4  = 6'd3;
  localparam logic [UADDR_W-1:0] UA_ADD   = 6'd4;
  localparam logic [UADDR_W-1:0] UA_ADD2  = 6'd5;
  localparam logic [UADDR_W-1:0] UA_ADD3  = 6'd6;
  localparam logic [UADDR_W-1:0] UA_NOP   = 6'd7;
  localparam logic [UADDR_W-1:0] UA_ILL   = 6'd8;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_GP, SRC_PC, SRC_C, SRC_MDR, SRC_MAR, SRC_IR
  } bus_src_e;

  typedef enum logic [1:0] {
    RSEL_LIT, RSEL_DST, RSEL_S1, RSEL_S2
  } reg_sel_e;

  typedef enum logic [1:0] {
    ALU_PASS, ALU_ADD, ALU_INC4
  } alu_fn_e;

  typedef enum logic [2:0] {
    SEQ_NEXT, SEQ_WAIT_MEM, SEQ_DISPATCH, SEQ_END, SEQ_HALT
  } seq_e;

  typedef struct packed {
    seq_e                 seq;
    bus_src_e             src;
    reg_sel_e             gp_sel;
    logic [GPR_IDX_W-1:0] gp_num;
    logic                 gp_in;
    logic                 a_ld;
    logic                 c_ld;
    logic                 pc_ld;
    logic                 ir_ld;
    logic                 mar_ld;
    logic                 mdr_ld;
    logic                 mem_start;
    logic                 mem_rd;
    alu_fn_e              alu;
    logic                 err;
  } uinstr_t;

  function automatic uinstr_t ucode_word(input logic [UADDR_W-1:0] a);
    uinstr_t u;
    u = '0;
    case (a)
      UA_FETCH: begin
        u.mem_start = 1'b1; u.mem_rd = 1'b1;
        u.src = SRC_PC; u.alu = ALU_INC4; u.c_ld = 1'b1;
      end
      UA_FET2: begin
        u.mem_rd = 1'b1; u.src = SRC_C; u.pc_ld = 1'b1;
      end
      UA_FET3: begin
        u.mem_rd = 1'b1; u.ir_ld = 1'b1; u.seq = SEQ_WAIT_MEM;
      end
      UA_FET4: u.seq = SEQ_DISPATCH;
      UA_ADD: begin
        u.src = SRC_GP; u.gp_sel = RSEL_S1; u.a_ld = 1'b1;
      end
      UA_ADD2: begin
        u.src = SRC_GP; u.gp_sel = RSEL_S2; u.alu = ALU_ADD; u.c_ld = 1'b1;
      end
      UA_ADD3: begin
        u.src = SRC_C; u.gp_sel = RSEL_DST; u.gp_in = 1'b1; u.seq = SEQ_END;
      end
      UA_NOP: u.seq = SEQ_END;
      default: begin
        u.seq = SEQ_HALT; u.err = 1'b1;
      end
    endcase
    return u;
  endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
(
  input  logic [UADDR_W-1:0] upc,
  output uinstr_t            uword
);

  uinstr_t rom [UDEPTH];

  for (genvar i = 0; i < UDEPTH; i++) begin : g_word
    assign rom[i] = ucode_word(UADDR_W'(i));
  end

  assign uword = rom[upc];

endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
(
  input  logic [UADDR_W-1:0] upc,
  input  seq_e               seq,
  input  logic               gp_in,
  input  logic [7:0]         opcode,
  input  logic               mem_rvalid,
  input  logic               wb_ready,
  output logic [UADDR_W-1:0] upc_nxt,
  output logic               fire
);

  logic mem_wait;
  logic wb_stall;

  assign mem_wait = (seq == SEQ_WAIT_MEM) && !mem_rvalid;
  assign wb_stall = gp_in && !wb_ready;
  assign fire     = !mem_wait && !wb_stall && (seq != SEQ_HALT);

  always_comb begin
    upc_nxt = upc + UADDR_W'(1);
    case (seq)
      SEQ_DISPATCH: begin
        case (opcode)
          OP_ADD:  upc_nxt = UA_ADD;
          OP_NOP:  upc_nxt = UA_NOP;
          default: upc_nxt = UA_ILL;
        endcase
      end
      SEQ_END:  upc_nxt = UA_FETCH;
      SEQ_HALT: upc_nxt = upc;
      default:  ;
    endcase
    if (mem_wait || wb_stall) upc_nxt = upc;
  end

endmodule

// File: rtl/useq_dp.sv
module useq_dp
  import useq_pkg::*;
#(
  parameter logic [XLEN-1:0] PC_RESET = '0,
  parameter logic [XLEN-1:0] REG_SEED = 32'h1001_0203
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fire,
  input  bus_src_e             src,
  input  reg_sel_e             gp_sel,
  input  logic [GPR_IDX_W-1:0] gp_num,
  input  logic                 gp_in,
  input  logic                 a_ld,
  input  logic                 c_ld,
  input  logic                 pc_ld,
  input  logic                 ir_ld,
  input  logic                 mar_ld,
  input  logic                 mdr_ld,
  input  alu_fn_e              alu,
  input  logic [XLEN-1:0]      mem_rdata,
  output logic [XLEN-1:0]      ir_q,
  output logic [XLEN-1:0]      pc_q,
  output logic [XLEN-1:0]      abus,
  output logic [GPR_IDX_W-1:0] gnum
);

  logic [XLEN-1:0] gpr [GPR_COUNT];
  logic [XLEN-1:0] a_q, c_q, mar_q, mdr_q;
  logic [XLEN-1:0] alu_y;

  always_comb begin
    case (gp_sel)
      RSEL_DST: gnum = ir_q[DST_LSB +: GPR_IDX_W];
      RSEL_S1:  gnum = ir_q[S1_LSB  +: GPR_IDX_W];
      RSEL_S2:  gnum = ir_q[S2_LSB  +: GPR_IDX_W];
      default:  gnum = gp_num;
    endcase
  end

  always_comb begin
    case (src)
      SRC_GP:  abus = gpr[gnum];
      SRC_PC:  abus = pc_q;
      SRC_C:   abus = c_q;
      SRC_MDR: abus = mdr_q;
      SRC_MAR: abus = mar_q;
      SRC_IR:  abus = ir_q;
      default: abus = '0;
    endcase
  end

  always_comb begin
    case (alu)
      ALU_ADD:  alu_y = a_q + abus;
      ALU_INC4: alu_y = abus + XLEN'(4);
      default:  alu_y = abus;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= PC_RESET;
      ir_q  <= '0;
      a_q   <= '0;
      c_q   <= '0;
      mar_q <= '0;
      mdr_q <= '0;
    end else if (fire) begin
      if (pc_ld)  pc_q  <= abus;
      if (ir_ld)  ir_q  <= mem_rdata;
      if (a_ld)   a_q   <= abus;
      if (c_ld)   c_q   <= alu_y;
      if (mar_ld) mar_q <= abus;
      if (mdr_ld) mdr_q <= abus;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < GPR_COUNT; k++) gpr[k] <= XLEN'(k) * REG_SEED;
    end else if (fire && gp_in) begin
      gpr[gnum] <= abus;
    end
  end

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(pc_q) |-> (pc_q == $past(pc_q) + XLEN'(4))); // R2

endmodule

// File: rtl/useq_core.sv
module useq_core
  import useq_pkg::*;
#(
  parameter logic [31:0] PC_RESET = 32'h0000_0000,
  parameter logic [31:0] REG_SEED = 32'h1001_0203
) (
  input  logic        clk,
  input  logic        rst,
  output logic        mem_rd_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_rvalid_i,
  input  logic [31:0] mem_rdata_i,
  output logic        wb_valid_o,
  input  logic        wb_ready_i,
  output logic [4:0]  wb_reg_o,
  output logic [31:0] wb_data_o,
  output logic [31:0] pc_o,
  output logic        err_o
);

  logic [UADDR_W-1:0]   upc_q, upc_nxt;
  uinstr_t              uw;
  logic                 fire;
  logic [XLEN-1:0]      ir_q, pc_q, abus, addr_q;
  logic [GPR_IDX_W-1:0] gnum;

  useq_store u_store (
    .upc   (upc_q),
    .uword (uw)
  );

  useq_next u_next (
    .upc        (upc_q),
    .seq        (uw.seq),
    .gp_in      (uw.gp_in),
    .opcode     (ir_q[OPC_LSB +: 8]),
    .mem_rvalid (mem_rvalid_i),
    .wb_ready   (wb_ready_i),
    .upc_nxt    (upc_nxt),
    .fire       (fire)
  );

  useq_dp #(
    .PC_RESET (PC_RESET),
    .REG_SEED (REG_SEED)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .src       (uw.src),
    .gp_sel    (uw.gp_sel),
    .gp_num    (uw.gp_num),
    .gp_in     (uw.gp_in),
    .a_ld      (uw.a_ld),
    .c_ld      (uw.c_ld),
    .pc_ld     (uw.pc_ld),
    .ir_ld     (uw.ir_ld),
    .mar_ld    (uw.mar_ld),
    .mdr_ld    (uw.mdr_ld),
    .alu       (uw.alu),
    .mem_rdata (mem_rdata_i),
    .ir_q      (ir_q),
    .pc_q      (pc_q),
    .abus      (abus),
    .gnum      (gnum)
  );

  always_ff @(posedge clk) begin
    if (rst) upc_q <= UA_FETCH;
    else     upc_q <= upc_nxt;
  end

  // read address captured when a request opens, held until it closes
  always_ff @(posedge clk) begin
    if (rst)                     addr_q <= PC_RESET;
    else if (fire && uw.mem_start) addr_q <= pc_q;
  end

  assign mem_rd_o   = uw.mem_rd;
  assign mem_addr_o = uw.mem_start ? pc_q : addr_q;
  assign wb_valid_o = uw.gp_in;
  assign wb_reg_o   = gnum;
  assign wb_data_o  = abus;
  assign pc_o       = pc_q;
  assign err_o      = uw.err;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_o && !mem_rvalid_i) |=> (mem_rd_o && $stable(mem_addr_o))); // R3

  AST_WB_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wb_valid_o && !wb_ready_i) |=>
      (wb_valid_o && $stable(wb_reg_o) && $stable(wb_data_o))); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_o |=> (err_o && !mem_rd_o && !wb_valid_o)); // R8

  AST_PC_FROZEN: assert property (@(posedge clk) disable iff (rst)
    err_o |=> $stable(pc_o)); // R8

  AST_END_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
    (uw.seq == SEQ_END && fire) |=> (upc_q == UA_FETCH && mem_rd_o)); // R7

endmodule

// File: tb/useq_core_bench.sv
module useq_core_bench;

  localparam logic [31:0] SEED  = 32'h1001_0203;
  localparam int          LIMIT = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_rd_o;
  logic [31:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        wb_valid_o;
  logic        wb_ready_i = 1'b1;
  logic [4:0]  wb_reg_o;
  logic [31:0] wb_data_o;
  logic [31:0] pc_o;
  logic        err_o;

  always #2 clk = ~clk;

  useq_core #(.PC_RESET(32'h0), .REG_SEED(SEED)) u_useq_core (
    .clk          (clk),
    .rst          (rst),
    .mem_rd_o     (mem_rd_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .wb_valid_o   (wb_valid_o),
    .wb_ready_i   (wb_ready_i),
    .wb_reg_o     (wb_reg_o),
    .wb_data_o    (wb_data_o),
    .pc_o         (pc_o),
    .err_o        (err_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  int n_ins = 0;
  int req_n = 0;
  int lat   = 0;
  int wcnt  = 0;
  int start_t [3];
  bit prev_rd = 1'b0;
  bit halt_watch = 1'b0;
  bit quiet_bad = 1'b0;

  logic [31:0] prog [8];
  logic [31:0] mdl  [32];
  logic [31:0] exp_addr_q [$];
  logic [36:0] exp_wb_q [$];

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: builds the program and pushes expected fetches and write-backs
  task automatic push_instr(input logic [7:0] op, input int d, input int s1, input int s2);
    prog[n_ins] = {op, 3'b000, 5'(d), 5'(s1), 5'(s2), 6'b0};
    exp_addr_q.push_back(32'(n_ins * 4));
    if (op == 8'h01) begin
      mdl[d] = mdl[s1] + mdl[s2];
      exp_wb_q.push_back({5'(d), mdl[d]});
    end
    n_ins++;
  endtask

  // memory model and scoreboard monitor, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      prev_rd = 1'b0;
      mem_rvalid_i = 1'b0;
      wb_ready_i = 1'b1;
    end else begin
      if (prev_rd && !mem_rd_o)
        check(mem_rvalid_i, "R3 request closed without response", 0, 1);
      if (mem_rd_o) begin
        if (!prev_rd) begin
          if (exp_addr_q.size() == 0) begin
            check(1'b0, "R2 unexpected fetch", 64'(mem_addr_o), 0);
          end else begin
            logic [31:0] e;
            e = exp_addr_q.pop_front();
            check(mem_addr_o == e, "R1 R2 fetch address", 64'(mem_addr_o), 64'(e));
          end
          if (req_n < 3) start_t[req_n] = cyc;
          lat  = (req_n >= 2) ? 1 + (req_n % 3) : 0;  // R3 waits
          wcnt = 0;
          req_n++;
        end else begin
          wcnt++;
        end
        mem_rvalid_i = (wcnt >= lat);
        mem_rdata_i  = prog[mem_addr_o[4:2]];
      end else begin
        mem_rvalid_i = 1'b0;
      end
      prev_rd = mem_rd_o;

      wb_ready_i = (req_n <= 2) ? 1'b1 : ((cyc % 3) == 0);
      if (wb_valid_o && wb_ready_i) begin
        if (exp_wb_q.size() == 0) begin
          check(1'b0, "R6 R7 unexpected write-back", {27'b0, wb_reg_o, wb_data_o}, 0);
        end else begin
          logic [36:0] w;
          w = exp_wb_q.pop_front();
          check({wb_reg_o, wb_data_o} == w, "R4 R5 R6 R9 write-back",
                {27'b0, wb_reg_o, wb_data_o}, {27'b0, w});
        end
      end
      if (halt_watch && (mem_rd_o || wb_valid_o)) quiet_bad = 1'b1;
    end
  end

  initial begin
    for (int k = 0; k < 32; k++) mdl[k] = 32'(k) * SEED;  // R5
    for (int k = 0; k < 8; k++)  prog[k] = '0;
    push_instr(8'h01, 3, 1, 2);     // R4
    push_instr(8'h00, 0, 0, 0);     // R7
    push_instr(8'h01, 1, 1, 1);     // R9 both sources and destination alike
    push_instr(8'h01, 0, 31, 3);
    push_instr(8'h01, 5, 5, 0);     // R9 destination equals source
    push_instr(8'h01, 31, 3, 31);
    push_instr(8'h00, 0, 0, 0);
    push_instr(8'h7F, 1, 2, 3);     // R8 illegal

    repeat (3) begin
      @(negedge clk);
      check(pc_o == 32'h0, "R1 reset pc", 64'(pc_o), 0);
      check(!err_o, "R1 reset err", 64'(err_o), 0);
      check(!wb_valid_o, "R1 reset write-back", 64'(wb_valid_o), 0);
    end
    @(posedge clk);
    #1 rst = 1'b0;

    while (!err_o && cyc < LIMIT) @(negedge clk);
    if (!err_o) begin
      check(1'b0, "watchdog expired", 64'(cyc), LIMIT);
    end else begin
      halt_watch = 1'b1;
      repeat (40) @(negedge clk);
      check(!quiet_bad, "R8 activity after halt", 64'(quiet_bad), 0);
      check(err_o, "R8 error flag sticky", 64'(err_o), 1);
      check(pc_o == 32'd32, "R2 R8 pc frozen", 64'(pc_o), 32);
      check(exp_addr_q.size() == 0, "R2 fetches outstanding", 64'(exp_addr_q.size()), 0);
      check(exp_wb_q.size() == 0, "R6 write-backs outstanding", 64'(exp_wb_q.size()), 0);
      check(start_t[1] - start_t[0] == 7, "R10 add cycle count",
            64'(start_t[1] - start_t[0]), 7);
      check(start_t[2] - start_t[1] == 5, "R7 R10 nop cycle count",
            64'(start_t[2] - start_t[1]), 5);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule